// File: doc/BRIEF.md
# Acknowledge polling sequencer

This block runs on the host side of a two-wire serial bus. After the host has issued a command that makes a slave start a slow nonvolatile write, the slave stops acknowledging its own address until the write has finished. The sequencer waits out that busy time. It keeps addressing the slave until the slave answers. It then either closes the transaction with a stop condition or goes straight on to the next instruction byte without releasing the bus.

The sequencer does not drive the bus wires. It asks a lower-level bit engine for one bus operation at a time: a start condition, a byte write (the engine also returns the slave's acknowledge bit), or a stop condition. Between two failed attempts it leaves a fixed gap of idle cycles. A programmable attempt limit bounds the wait. When the limit is reached, the sequencer issues a stop and pulses a timeout flag instead of a completion flag.

Top module: `ackpoll_seq`

## Requirements
- R1: While reset is asserted and directly after it is released, `busy`, `bus_req`, `done` and `timeout` are all low.
- R2: When `poll_req` is high and the block is idle, the block becomes busy and requests a start condition (`bus_op` = 0) in the next cycle.
- R3: When a start condition completes (`bus_done` high), the next request is a byte write (`bus_op` = 1) of the address byte `{poll_addr, 1'b0}`.
- R4: When the address write completes with `bus_ack` low and the attempt limit is not yet reached, no request is made for exactly `GAP_CYC` cycles, and then a new start condition is requested.
- R5: When the address write is acknowledged and `chain_next` was low at acceptance, the block requests a stop (`bus_op` = 2). `done` goes high for one cycle, one cycle after that stop completes.
- R6: When the address write is acknowledged and `chain_next` was high at acceptance, the block next writes `next_instr` with no start or stop in between. `done` pulses one cycle after that write completes, and no stop is issued.
- R7: When the number of unacknowledged address writes reaches `max_attempts`, the block requests a stop. `timeout` goes high for one cycle, one cycle after that stop completes. A limit of 0 behaves as a limit of 1.
- R8: `done` and `timeout` are single-cycle pulses. They are never high together, and `busy` is low while either is high.
- R9: A `poll_req` that arrives while the block is busy is ignored. It neither changes the address nor adds attempts.
- R10: A request holds `bus_req`, `bus_op` and `bus_wdata` steady until the bit engine answers with `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_req | input | 1 | Start a polling run (taken only when idle) |
| poll_addr | input | 7 | Slave address, latched at acceptance |
| chain_next | input | 1 | 1: go on with `next_instr` after the acknowledge, 0: end with stop |
| next_instr | input | 8 | Instruction byte sent when chaining |
| max_attempts | input | ATT_W | Attempt limit, latched at acceptance (0 treated as 1) |
| busy | output | 1 | A polling run is in progress |
| done | output | 1 | One-cycle pulse: slave answered, run completed |
| timeout | output | 1 | One-cycle pulse: attempt limit reached, stop issued |
| bus_req | output | 1 | Bus operation requested |
| bus_op | output | 2 | Operation: 0 start, 1 write byte, 2 stop |
| bus_wdata | output | 8 | Byte to write for operation 1 |
| bus_done | input | 1 | Bit engine finished the current operation |
| bus_ack | input | 1 | Slave acknowledge of a written byte, valid with `bus_done` |

## Verification
A wrong state or counter shows up on the bus-operation port within one operation. An extra or missing start shows in the attempt count. A miscounted gap shows as the wrong number of idle busy cycles between attempts. A wrong exit branch gives a stop where an instruction byte was due, or the reverse. Bad pulse logic shows one cycle after the final operation, as a `done`/`timeout` that is missing, doubled, swapped or late. The bench models the bit engine with a scripted number of refusals. It therefore counts starts, stops, address bytes and idle cycles at the port and compares them with values worked out from the requirements.

// File: rtl/ackpoll_pkg.sv
// Shared types for the acknowledge polling sequencer.
// Assumes the bit engine decodes the operation code values listed here.
package ackpoll_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_STOP  = 2'd2
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_GAP,
        ST_INSTR,
        ST_STOP_OK,
        ST_STOP_TO
    } seq_state_e;
endpackage

// File: rtl/ackpoll_retry_ctr.sv
// Attempt counter and inter-attempt gap timer.
// Assumes: arm is asserted once, when a run is accepted; nack marks a refused address byte;
// gap_load is asserted on the same cycle the sequencer enters its wait state.
module ackpoll_retry_ctr #(
    parameter int ATT_W   = 8,
    parameter int GAP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [ATT_W-1:0] max_in,
    input  logic             nack,
    input  logic             gap_load,
    output logic             limit_hit,
    output logic             gap_done
);
    localparam int CW = ATT_W + 1;
    localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    logic [ATT_W-1:0] max_q;
    logic [ATT_W-1:0] tries_q;
    logic [CW-1:0]    max_eff;
    logic [CW-1:0]    tries_next;

    // Latch the limit and clear the count at acceptance; count refusals afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q   <= '0;
            tries_q <= '0;
        end else if (arm) begin
            max_q   <= max_in;
            tries_q <= '0;
        end else if (nack) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    // A refusal hits the limit when the count including it reaches the limit (0 acts as 1).
    always_comb begin
        max_eff    = (max_q == '0) ? CW'(1) : {1'b0, max_q};
        tries_next = {1'b0, tries_q} + CW'(1);
        limit_hit  = (tries_next >= max_eff);
    end

    generate
        if (GAP_CYC > 1) begin : g_gap
            logic [GW-1:0] gap_q;
            // Gap timer: loaded with GAP_CYC-1, counts down to zero while waiting.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gap_q <= '0;
                else if (gap_load)
                    gap_q <= GW'(GAP_CYC - 1);
                else if (gap_q != '0)
                    gap_q <= gap_q - 1'b1;
            end
            assign gap_done = (gap_q == '0);
        end else begin : g_nogap
            assign gap_done = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/ackpoll_fsm.sv
// Sequencing state machine: start, address, optional gap, then stop or chained instruction.
// Assumes bus_done is a single-cycle answer from the bit engine for the current request.
module ackpoll_fsm
    import ackpoll_pkg::*;
#(
    parameter int GAP_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       poll_req,
    input  logic       chain_in,
    input  logic       bus_done,
    input  logic       bus_ack,
    input  logic       limit_hit,
    input  logic       gap_done,
    output seq_state_e state,
    output logic       arm,
    output logic       nack,
    output logic       gap_load,
    output logic       done_p,
    output logic       to_p
);
    seq_state_e state_q, state_d;
    logic       chain_q;

    // Next-state selection and control strobes.
    always_comb begin
        state_d  = state_q;
        arm      = (state_q == ST_IDLE) && poll_req;
        nack     = (state_q == ST_ADDR) && bus_done && !bus_ack;
        gap_load = 1'b0;
        case (state_q)
            ST_IDLE:  if (poll_req) state_d = ST_START;
            ST_START: if (bus_done) state_d = ST_ADDR;
            ST_ADDR: begin
                if (bus_done) begin
                    if (bus_ack)
                        state_d = chain_q ? ST_INSTR : ST_STOP_OK;
                    else if (limit_hit)
                        state_d = ST_STOP_TO;
                    else if (GAP_CYC == 0)
                        state_d = ST_START;
                    else begin
                        state_d  = ST_GAP;
                        gap_load = 1'b1;
                    end
                end
            end
            ST_GAP:   if (gap_done) state_d = ST_START;
            ST_INSTR, ST_STOP_OK, ST_STOP_TO:
                      if (bus_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register, chain flag latch and end-of-run pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chain_q <= 1'b0;
            done_p  <= 1'b0;
            to_p    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (arm) chain_q <= chain_in;
            done_p  <= bus_done && ((state_q == ST_INSTR) || (state_q == ST_STOP_OK));
            to_p    <= bus_done && (state_q == ST_STOP_TO);
        end
    end

    assign state = state_q;
endmodule

// File: rtl/ackpoll_bus_drv.sv
// Maps the sequencer state onto the bit-engine request port.
// Assumes a request stays up while the state stays, so it is held until bus_done.
module ackpoll_bus_drv
    import ackpoll_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] instr_in,
    input  seq_state_e    state,
    output logic          bus_req,
    output logic [1:0]    bus_op,
    output logic [DW-1:0] bus_wdata
);
    localparam int PAD = DW - AW;

    logic [DW-1:0] addr_byte_q;
    logic [DW-1:0] instr_q;

    // Capture the address byte (write direction) and the chained instruction at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_byte_q <= '0;
            instr_q     <= '0;
        end else if (load) begin
            addr_byte_q <= {addr_in, {PAD{1'b0}}};
            instr_q     <= instr_in;
        end
    end

    // Operation, byte and request level for the current state.
    always_comb begin
        bus_req   = 1'b1;
        bus_op    = OP_START;
        bus_wdata = addr_byte_q;
        case (state)
            ST_START:   bus_op = OP_START;
            ST_ADDR:    bus_op = OP_WRITE;
            ST_INSTR: begin
                bus_op    = OP_WRITE;
                bus_wdata = instr_q;
            end
            ST_STOP_OK, ST_STOP_TO: bus_op = OP_STOP;
            default:    bus_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/ackpoll_seq.sv
// Top of the acknowledge polling sequencer.
// Waits out a slave's nonvolatile write by re-addressing it until it acknowledges,
// then ends with stop or chains an instruction byte. Assumes one bit engine answers each request.
module ackpoll_seq #(
    parameter int ATT_W   = 8,
    parameter int GAP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_req,
    input  logic [6:0]       poll_addr,
    input  logic             chain_next,
    input  logic [7:0]       next_instr,
    input  logic [ATT_W-1:0] max_attempts,
    output logic             busy,
    output logic             done,
    output logic             timeout,
    output logic             bus_req,
    output logic [1:0]       bus_op,
    output logic [7:0]       bus_wdata,
    input  logic             bus_done,
    input  logic             bus_ack
);
    import ackpoll_pkg::*;

    seq_state_e state;
    logic       arm, nack, gap_load, limit_hit, gap_done;

    ackpoll_retry_ctr #(.ATT_W(ATT_W), .GAP_CYC(GAP_CYC)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .max_in    (max_attempts),
        .nack      (nack),
        .gap_load  (gap_load),
        .limit_hit (limit_hit),
        .gap_done  (gap_done)
    );

    ackpoll_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_req  (poll_req),
        .chain_in  (chain_next),
        .bus_done  (bus_done),
        .bus_ack   (bus_ack),
        .limit_hit (limit_hit),
        .gap_done  (gap_done),
        .state     (state),
        .arm       (arm),
        .nack      (nack),
        .gap_load  (gap_load),
        .done_p    (done),
        .to_p      (timeout)
    );

    ackpoll_bus_drv #(.AW(7), .DW(8)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (arm),
        .addr_in   (poll_addr),
        .instr_in  (next_instr),
        .state     (state),
        .bus_req   (bus_req),
        .bus_op    (bus_op),
        .bus_wdata (bus_wdata)
    );

    // Busy whenever a run is in progress.
    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ackpoll_checker.sv
// Port-level properties of the polling sequencer, bound to every instance of the top.
module ackpoll_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       timeout,
    input logic       bus_req,
    input logic [1:0] bus_op,
    input logic [7:0] bus_wdata,
    input logic       bus_done,
    input logic       bus_ack
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_TO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout); // R8
    AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |-> !busy); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_op) && $stable(bus_wdata))); // R10
    AST_START_THEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_op == 2'd0 && bus_done) |=> (bus_req && bus_op == 2'd1)); // R3
    AST_NACK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_op == 2'd1 && bus_done && !bus_ack) |=> !(bus_req && bus_op == 2'd1)); // R4
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy); // R2
endmodule

bind ackpoll_seq ackpoll_checker u_ackpoll_chk (.*);

// File: tb/tb_ackpoll_seq.sv
// Bench: a scripted bit-engine model answers each request after a fixed latency and
// refuses a chosen number of address bytes; a vector table drives runs, then directed tests.
module tb_ackpoll_seq;
    localparam int ATT_W   = 8;
    localparam int GAP_CYC = 4;
    localparam int LAT     = 2;
    localparam int NVEC    = 10;
    localparam logic [7:0] INSTR = 8'hC3;

    // {refusals, limit, chain, exp_done, exp_starts, exp_stops, exp_instr, exp_idle[7:0]}
    localparam logic [35:0] VEC [NVEC] = '{
        36'h0_5_0_1_1_1_0_00,
        36'h3_5_0_1_4_1_0_0C,
        36'h0_5_1_1_1_0_1_00,
        36'h2_5_1_1_3_0_1_08,
        36'h9_3_0_0_3_1_0_08,
        36'h9_3_1_0_3_1_0_08,
        36'h4_5_0_1_5_1_0_10,
        36'h5_5_0_0_5_1_0_10,
        36'h9_0_0_0_1_1_0_00,
        36'h9_1_1_0_1_1_0_00
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             poll_req = 1'b0;
    logic [6:0]       poll_addr = '0;
    logic             chain_next = 1'b0;
    logic [7:0]       next_instr = '0;
    logic [ATT_W-1:0] max_attempts = '0;
    logic             busy, done, timeout, bus_req;
    logic [1:0]       bus_op;
    logic [7:0]       bus_wdata;
    logic             bus_done = 1'b0;
    logic             bus_ack = 1'b0;

    int total = 0;
    int fails = 0;

    // Bit-engine model state and port observations.
    int         refuse_n = 0;
    logic [7:0] exp_addr = '0;
    int lat_cnt = 0, wr_since_start = 0, addr_seen = 0;
    int starts = 0, stops = 0, instr_cnt = 0, idle_cnt = 0;
    int addr_err = 0, hold_err = 0, lag_err = 0, done_cnt = 0, to_cnt = 0;
    logic [7:0] instr_last = '0;
    logic [1:0] held_op = '0;
    logic [7:0] held_data = '0;
    bit         final_prev = 1'b0;

    always #4 clk = ~clk;

    ackpoll_seq #(.ATT_W(ATT_W), .GAP_CYC(GAP_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .poll_req(poll_req), .poll_addr(poll_addr),
        .chain_next(chain_next), .next_instr(next_instr), .max_attempts(max_attempts),
        .busy(busy), .done(done), .timeout(timeout), .bus_req(bus_req), .bus_op(bus_op),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_ack(bus_ack)
    );

    // Engine model and monitor, both on the falling edge.
    always @(negedge clk) begin
        bit fin_now;
        fin_now = 1'b0;
        if (rst_n) begin
            if ((done || timeout) != final_prev) lag_err++;
            if ((done || timeout) && busy) lag_err++;
            if (done && timeout) lag_err++;
            if (done) done_cnt++;
            if (timeout) to_cnt++;
            if (busy && !bus_req) idle_cnt++;
        end
        if (bus_done) begin
            bus_done = 1'b0;
            bus_ack  = 1'b0;
            lat_cnt  = 0;
        end else if (bus_req) begin
            if (lat_cnt > 0 && (bus_op != held_op || bus_wdata != held_data)) hold_err++;
            held_op   = bus_op;
            held_data = bus_wdata;
            lat_cnt++;
            if (lat_cnt >= LAT) begin
                bus_done = 1'b1;
                case (bus_op)
                    2'd0: begin starts++; wr_since_start = 0; end
                    2'd1: begin
                        if (wr_since_start == 0) begin
                            if (bus_wdata != exp_addr) addr_err++;
                            bus_ack = (addr_seen >= refuse_n);
                            addr_seen++;
                        end else begin
                            instr_cnt++;
                            instr_last = bus_wdata;
                            bus_ack = 1'b1;
                            fin_now = 1'b1;
                        end
                        wr_since_start++;
                    end
                    2'd2: begin stops++; fin_now = 1'b1; end
                    default: addr_err++;
                endcase
            end
        end else begin
            lat_cnt = 0;
        end
        final_prev = fin_now;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One polling run; late_req pulses a second request while busy (R9).
    task automatic run(input int nk, input int mx, input bit ch, input logic [6:0] ad,
                       input bit late_req);
        @(negedge clk); #1;
        refuse_n = nk; exp_addr = {ad, 1'b0}; addr_seen = 0; wr_since_start = 0;
        starts = 0; stops = 0; instr_cnt = 0; idle_cnt = 0; addr_err = 0;
        hold_err = 0; lag_err = 0; done_cnt = 0; to_cnt = 0; instr_last = '0;
        poll_req = 1'b1; poll_addr = ad; chain_next = ch; next_instr = INSTR;
        max_attempts = ATT_W'(mx);
        @(negedge clk); #1;
        poll_req = 1'b0;
        chk("R2 start requested", int'(bus_req && bus_op == 2'd0 && busy), 1);
        if (late_req) begin
            repeat (3) @(negedge clk);
            #1;
            poll_req = 1'b1; poll_addr = ~ad; max_attempts = '0;
            @(negedge clk); #1;
            poll_req = 1'b0;
        end
        for (int i = 0; i < 3000 && (done_cnt + to_cnt) == 0; i++) begin
            @(negedge clk); #1;
        end
        repeat (6) @(negedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 bus_req in reset", int'(bus_req), 0);
        chk("R1 pulses in reset", int'(done || timeout), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 bus_req after reset", int'(bus_req), 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [35:0] e;
            e = VEC[v];
            run(int'(e[35:32]), int'(e[31:28]), e[27:24] != 0, 7'h50 + 7'(v), 1'b0);
            chk("R5 R6 done count", done_cnt, int'(e[23:20]));
            chk("R7 timeout count", to_cnt, 1 - int'(e[23:20]));
            chk("R4 R7 start count", starts, int'(e[19:16]));
            chk("R5 R6 R7 stop count", stops, int'(e[15:12]));
            chk("R6 instruction writes", instr_cnt, int'(e[11:8]));
            if (e[11:8] != 0) chk("R6 instruction value", int'(instr_last), int'(INSTR));
            chk("R4 idle gap cycles", idle_cnt, int'(e[7:0]));
            chk("R3 address byte", addr_err, 0);
            chk("R8 pulse timing", lag_err, 0);
            chk("R10 request hold", hold_err, 0);
        end

        // R9: second request while busy must not alter address or attempts.
        run(2, 5, 1'b0, 7'h2A, 1'b1);
        chk("R9 starts unchanged", starts, 3);
        chk("R9 address unchanged", addr_err, 0);
        chk("R9 single done", done_cnt, 1);
        chk("R9 no timeout", to_cnt, 0);
        chk("R9 idle after run", int'(busy), 0);

        // R7 corner: large limit not reached on the last allowed attempt.
        run(6, 7, 1'b1, 7'h11, 1'b0);
        chk("R7 ack on last allowed attempt", done_cnt, 1);
        chk("R6 chained after late ack", instr_cnt, 1);
        chk("R4 gaps before late ack", idle_cnt, 6 * GAP_CYC);

        // R1: reset in mid-run returns to quiet state.
        @(negedge clk); #1;
        refuse_n = 100; poll_req = 1'b1; max_attempts = '1;
        @(negedge clk); #1;
        poll_req = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R1 busy after mid-run reset", int'(busy), 0);
        chk("R1 bus_req after mid-run reset", int'(bus_req), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule